// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block adds character-based flow control to a serial transmitter and receiver pair. Four character registers hold the resume characters (Xon1, Xon2) and the pause characters (Xoff1, Xoff2). A five-bit configuration word sets the mode. Its top bit is an enable. Two bits select the transmit mode and two bits select the receive mode, and each direction is decoded on its own. The configuration word takes a write only while the line-control value presented to the block equals 0xBF.

On the receive side, every byte from the deserializer is compared against the selected characters. The match is on one character, or on a pair of characters that arrive as consecutive bytes. A pause match sets `tx_halt` and a resume match clears it. Matched characters are removed from the stream, and every other byte is passed on with a valid strobe.

On the transmit side, a request to send resume or pause places the selected one- or two-character sequence ahead of queued data. The request is acknowledged when the last character of the sequence is taken by the transmitter. Received bytes must be at least two cycles apart, which any serial line rate satisfies.

Top module: `swfc_top`

## Requirements
- R1: After reset, `tx_halt`, `rx_out_valid` and `tx_out_valid` are 0, the configuration word is 0 (flow control off), and all character registers are 0.
- R2: A configuration write is accepted only in a cycle where `cfg_wr` is 1 and `lcr_value` is 0xBF. A write with any other `lcr_value` leaves the configuration unchanged.
- R3: When configuration bit 4 (enable) is 0, no received byte is compared: every byte passes through and `tx_halt` is held at 0. A flow-control request is acknowledged in the same cycle it is raised, and no character is sent.
- R4: Receive mode is set by configuration bits 1:0. With 10, a byte equal to Xon1 clears `tx_halt` and a byte equal to Xoff1 sets it. With 01, Xon2 and Xoff2 play these roles. With 00, no byte is compared. Each matched byte is dropped from the output stream.
- R5: With receive bits 11, `tx_halt` is set only by Xoff1 followed by Xoff2 as consecutive received bytes, and cleared only by Xon1 followed by Xon2. Both bytes of a completed pair are dropped.
- R6: In receive mode 11, suppose a first character is followed by a byte that does not complete its pair. The held first character is then released to the output, and the new byte is checked again as a possible first character. If it is not a first character, it follows on the next cycle.
- R7: A received byte that is not consumed appears on `rx_out_data` with `rx_out_valid` one cycle after it was presented. Byte order is preserved.
- R8: Transmit mode is set by configuration bits 3:2. With 10, the block sends Xon1 or Xoff1. With 01, it sends Xon2 or Xoff2. With 11, it sends Xon1 then Xon2, or Xoff1 then Xoff2. With 00, it sends nothing. `fc_kind` = 1 selects the pause characters and 0 selects the resume characters.
- R9: While a request is pending or in progress, flow-control characters take the transmitter ahead of queued data. They are sent even while `tx_halt` is 1. Queued data is never handed over while `tx_halt` is 1.
- R10: `fc_ack` is 1 in the cycle in which the last character of the sequence is handed over (`tx_out_valid` and `tx_out_ready` both 1). The requester holds `fc_req` until that cycle.
- R11: The character sequence is fixed when a request is accepted. A configuration change during the sequence does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcr_value | input | 8 | Current line-control value; 0xBF unlocks configuration writes |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Bit 4 enable, bits 3:2 transmit mode, bits 1:0 receive mode |
| chr_wr | input | 1 | Character register write strobe |
| chr_sel | input | 2 | 0 Xon1, 1 Xon2, 2 Xoff1, 3 Xoff2 |
| chr_wdata | input | 8 | Character value to write |
| rx_in_valid | input | 1 | Received byte strobe (at least two cycles apart) |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Passed-through byte strobe |
| rx_out_data | output | 8 | Passed-through byte |
| tx_halt | output | 1 | Pause the local transmitter |
| fc_req | input | 1 | Request to send a flow-control sequence |
| fc_kind | input | 1 | 1 pause (Xoff), 0 resume (Xon) |
| fc_ack | output | 1 | Request completed this cycle |
| tx_data_valid | input | 1 | Queued data byte available |
| tx_data | input | 8 | Queued data byte |
| tx_data_ready | output | 1 | Queued data byte taken this cycle |
| tx_out_valid | output | 1 | Byte offered to the transmitter |
| tx_out_data | output | 8 | Byte offered to the transmitter |
| tx_out_ready | input | 1 | Transmitter takes the byte |

## Verification
In one cycle, both a flow-control request and a queued data byte can compete for the transmitter. The bench raises `fc_req` and `tx_data_valid` after the same clock edge. The scoreboard then requires the control characters to leave before the data byte. A second collision arises when a pause request is made while the receive side holds `tx_halt`. There the characters must still leave, while the data byte waits until a received resume clears the halt. In both cases the transmit monitor compares each byte handed over against the queue the driver filled from the requirements.

// File: rtl/swfc_pkg.sv
package swfc_pkg;

  // which pair-half is held by the dual-character receive matcher
  typedef enum logic [1:0] {
    HOLD_NONE = 2'd0,
    HOLD_ON   = 2'd1,
    HOLD_OFF  = 2'd2
  } hold_e;

  // number of characters a transmit mode selection emits
  function automatic logic [1:0] seq_len(input logic [1:0] sel);
    return {1'b0, sel[1]} + {1'b0, sel[0]};
  endfunction

  // character of a set: set1 chosen when use_first, else set2
  function automatic logic [7:0] pick_char(input logic use_first,
                                           input logic [7:0] c1,
                                           input logic [7:0] c2);
    return use_first ? c1 : c2;
  endfunction

endpackage

// File: rtl/swfc_cfg_regs.sv
module swfc_cfg_regs #(
  parameter int W        = 8,
  parameter int CFG_W    = 5,
  parameter logic [7:0] LCR_KEY = 8'hBF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       lcr_value,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             chr_wr,
  input  logic [1:0]       chr_sel,
  input  logic [W-1:0]     chr_wdata,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_accept,
  output logic [W-1:0]     xon1,
  output logic [W-1:0]     xon2,
  output logic [W-1:0]     xoff1,
  output logic [W-1:0]     xoff2
);
  localparam int NCHR = 4;

  logic [NCHR-1:0][W-1:0] chr_q;

  assign cfg_accept = cfg_wr && (lcr_value == LCR_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_word <= '0;
    else if (cfg_accept) cfg_word <= cfg_wdata;
  end

  for (genvar i = 0; i < NCHR; i++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               chr_q[i] <= '0;
      else if (chr_wr && (chr_sel == 2'(i)))    chr_q[i] <= chr_wdata;
    end
  end

  assign xon1  = chr_q[0];
  assign xon2  = chr_q[1];
  assign xoff1 = chr_q[2];
  assign xoff2 = chr_q[3];
endmodule

// File: rtl/swfc_rx_match.sv
module swfc_rx_match
  import swfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fc_en,
  input  logic [1:0]   rx_sel,
  input  logic [W-1:0] xon1,
  input  logic [W-1:0] xon2,
  input  logic [W-1:0] xoff1,
  input  logic [W-1:0] xoff2,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         halt,
  output logic         match_set,
  output logic         match_clr
);
  hold_e        hold_q, hold_n;
  logic [W-1:0] held_q, held_n;
  logic         spill_v_q, spill_v_n;
  logic [W-1:0] spill_q, spill_n;
  logic         emit_v;
  logic [W-1:0] emit_d;
  logic [1:0]   eff;
  logic [W-1:0] on_c, off_c;

  assign eff   = fc_en ? rx_sel : 2'b00;
  assign on_c  = pick_char(eff[1], xon1, xon2);
  assign off_c = pick_char(eff[1], xoff1, xoff2);

  always_comb begin
    emit_v    = spill_v_q;
    emit_d    = spill_q;
    spill_v_n = 1'b0;
    spill_n   = spill_q;
    hold_n    = hold_q;
    held_n    = held_q;
    match_set = 1'b0;
    match_clr = 1'b0;
    if (in_valid) begin
      emit_v = 1'b0;
      emit_d = in_data;
      unique case (eff)
        2'b10, 2'b01: begin
          if (in_data == on_c)       match_clr = 1'b1;
          else if (in_data == off_c) match_set = 1'b1;
          else                       emit_v    = 1'b1;
        end
        2'b11: begin
          if (hold_q == HOLD_ON && in_data == xon2) begin
            match_clr = 1'b1;
            hold_n    = HOLD_NONE;
          end else if (hold_q == HOLD_OFF && in_data == xoff2) begin
            match_set = 1'b1;
            hold_n    = HOLD_NONE;
          end else begin
            if (hold_q != HOLD_NONE) begin
              emit_v = 1'b1;
              emit_d = held_q;
            end
            held_n = in_data;
            if (in_data == xon1)       hold_n = HOLD_ON;
            else if (in_data == xoff1) hold_n = HOLD_OFF;
            else begin
              hold_n = HOLD_NONE;
              if (hold_q != HOLD_NONE) begin
                spill_v_n = 1'b1;
                spill_n   = in_data;
              end else begin
                emit_v = 1'b1;
              end
            end
          end
        end
        default: emit_v = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= HOLD_NONE;
      held_q    <= '0;
      spill_v_q <= 1'b0;
      spill_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      halt      <= 1'b0;
    end else begin
      hold_q    <= hold_n;
      held_q    <= held_n;
      spill_v_q <= spill_v_n;
      spill_q   <= spill_n;
      out_valid <= emit_v;
      if (emit_v) out_data <= emit_d;
      if (!fc_en)         halt <= 1'b0;
      else if (match_set) halt <= 1'b1;
      else if (match_clr) halt <= 1'b0;
    end
  end
endmodule

// File: rtl/swfc_tx_insert.sv
module swfc_tx_insert
  import swfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fc_en,
  input  logic [1:0]   tx_sel,
  input  logic [W-1:0] xon1,
  input  logic [W-1:0] xon2,
  input  logic [W-1:0] xoff1,
  input  logic [W-1:0] xoff2,
  input  logic         halt,
  input  logic         fc_req,
  input  logic         fc_kind,
  output logic         fc_ack,
  input  logic         data_valid,
  input  logic [W-1:0] data,
  output logic         data_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         busy,
  output logic         last_handoff
);
  logic         idx_q, two_q;
  logic [W-1:0] c0_q, c1_q;
  logic [1:0]   eff, len;
  logic         start, ack_empty;
  logic [W-1:0] first_c, second_c;

  assign eff      = fc_en ? tx_sel : 2'b00;
  assign len      = seq_len(eff);
  assign first_c  = eff[1] ? pick_char(fc_kind, xoff1, xon1)
                           : pick_char(fc_kind, xoff2, xon2);
  assign second_c = pick_char(fc_kind, xoff2, xon2);

  assign start        = !busy && fc_req && (len != 2'd0);
  assign ack_empty    = !busy && fc_req && (len == 2'd0);
  assign last_handoff = busy && out_ready && (idx_q == two_q);
  assign fc_ack       = ack_empty || last_handoff;

  assign out_valid  = busy || (data_valid && !halt && !fc_req);
  assign out_data   = busy ? (idx_q ? c1_q : c0_q) : data;
  assign data_ready = !busy && !fc_req && !halt && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx_q <= 1'b0;
      two_q <= 1'b0;
      c0_q  <= '0;
      c1_q  <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      idx_q <= 1'b0;
      two_q <= (len == 2'd2);
      c0_q  <= first_c;
      c1_q  <= second_c;
    end else if (busy && out_ready) begin
      if (last_handoff) busy  <= 1'b0;
      else              idx_q <= 1'b1;
    end
  end
endmodule

// File: rtl/swfc_top.sv
module swfc_top #(
  parameter int W = 8,
  parameter logic [7:0] LCR_KEY = 8'hBF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   lcr_value,
  input  logic         cfg_wr,
  input  logic [4:0]   cfg_wdata,
  input  logic         chr_wr,
  input  logic [1:0]   chr_sel,
  input  logic [W-1:0] chr_wdata,
  input  logic         rx_in_valid,
  input  logic [W-1:0] rx_in_data,
  output logic         rx_out_valid,
  output logic [W-1:0] rx_out_data,
  output logic         tx_halt,
  input  logic         fc_req,
  input  logic         fc_kind,
  output logic         fc_ack,
  input  logic         tx_data_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_data_ready,
  output logic         tx_out_valid,
  output logic [W-1:0] tx_out_data,
  input  logic         tx_out_ready
);
  localparam int CFG_W = 5;

  logic [CFG_W-1:0] cfg_word;
  logic             cfg_accept;
  logic [W-1:0]     xon1, xon2, xoff1, xoff2;
  logic             fc_en;
  logic             match_set, match_clr, tx_busy, last_handoff;

  swfc_cfg_regs #(.W(W), .CFG_W(CFG_W), .LCR_KEY(LCR_KEY)) u_cfg (
    .clk, .rst_n, .lcr_value, .cfg_wr, .cfg_wdata, .chr_wr, .chr_sel,
    .chr_wdata, .cfg_word, .cfg_accept, .xon1, .xon2, .xoff1, .xoff2
  );

  assign fc_en = cfg_word[4];

  swfc_rx_match #(.W(W)) u_rx (
    .clk, .rst_n, .fc_en, .rx_sel(cfg_word[1:0]), .xon1, .xon2, .xoff1,
    .xoff2, .in_valid(rx_in_valid), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_data(rx_out_data), .halt(tx_halt),
    .match_set, .match_clr
  );

  swfc_tx_insert #(.W(W)) u_tx (
    .clk, .rst_n, .fc_en, .tx_sel(cfg_word[3:2]), .xon1, .xon2, .xoff1,
    .xoff2, .halt(tx_halt), .fc_req, .fc_kind, .fc_ack,
    .data_valid(tx_data_valid), .data(tx_data), .data_ready(tx_data_ready),
    .out_valid(tx_out_valid), .out_data(tx_out_data),
    .out_ready(tx_out_ready), .busy(tx_busy), .last_handoff
  );
endmodule

// File: rtl/swfc_checker.sv
module swfc_checker #(
  parameter logic [7:0] LCR_KEY = 8'hBF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] lcr_value,
  input logic [4:0] cfg_word,
  input logic       fc_en,
  input logic       rx_in_valid,
  input logic       rx_out_valid,
  input logic       tx_halt,
  input logic       match_set,
  input logic       match_clr,
  input logic       fc_req,
  input logic       fc_ack,
  input logic       tx_busy,
  input logic       last_handoff,
  input logic       tx_out_valid,
  input logic       tx_out_ready,
  input logic       tx_data_ready
);
  p_cfg_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> $past(cfg_wr && (lcr_value == LCR_KEY)));

  p_halt_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(rx_in_valid));

  p_halt_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_halt) |-> ($past(rx_in_valid) || !$past(fc_en)));

  p_match_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_set || match_clr) |=> !rx_out_valid);

  p_rx_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid |=> !rx_in_valid);

  p_no_data_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_data_ready |-> (!tx_halt && !tx_busy));

  p_busy_offers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> tx_out_valid);

  p_ack_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fc_ack |-> fc_req);

  p_ack_handoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last_handoff |-> (fc_ack && tx_out_valid && tx_out_ready));

  p_disabled_no_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> !tx_halt);
endmodule

bind swfc_top swfc_checker #(.LCR_KEY(LCR_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .lcr_value(lcr_value),
  .cfg_word(cfg_word), .fc_en(fc_en), .rx_in_valid(rx_in_valid),
  .rx_out_valid(rx_out_valid), .tx_halt(tx_halt), .match_set(match_set),
  .match_clr(match_clr), .fc_req(fc_req), .fc_ack(fc_ack),
  .tx_busy(tx_busy), .last_handoff(last_handoff),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
  .tx_data_ready(tx_data_ready)
);

// File: tb/swfc_top_tb_top.sv
module swfc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KEY = 8'hBF;
  localparam logic [7:0] XON1 = 8'h11, XON2 = 8'h21, XOFF1 = 8'h13, XOFF2 = 8'h23;

  logic       clk = 0, rst_n = 0;
  logic [7:0] lcr_value = 0;
  logic       cfg_wr = 0;
  logic [4:0] cfg_wdata = 0;
  logic       chr_wr = 0;
  logic [1:0] chr_sel = 0;
  logic [7:0] chr_wdata = 0;
  logic       rx_in_valid = 0;
  logic [7:0] rx_in_data = 0;
  logic       rx_out_valid, tx_halt, fc_ack, tx_data_ready, tx_out_valid;
  logic [7:0] rx_out_data, tx_out_data;
  logic       fc_req = 0, fc_kind = 0, tx_data_valid = 0, tx_out_ready = 1;
  logic [7:0] tx_data = 0;

  int checks = 0, fails = 0;
  string rx_tag = "R7", tx_tag = "R8";
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  swfc_top dut_i (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rx monitor: scoreboard pop
  always @(negedge clk) if (rst_n && rx_out_valid) begin
    if (rx_q.size() == 0) check(0, {rx_tag, " unexpected rx byte"}, rx_out_data, 0);
    else begin
      logic [7:0] e;
      e = rx_q.pop_front();
      check(rx_out_data == e, rx_tag, rx_out_data, e);
    end
  end

  // tx monitor
  always @(negedge clk) if (rst_n && tx_out_valid && tx_out_ready) begin
    if (tx_q.size() == 0) check(0, {tx_tag, " unexpected tx byte"}, tx_out_data, 0);
    else begin
      logic [7:0] e;
      e = tx_q.pop_front();
      check(tx_out_data == e, tx_tag, tx_out_data, e);
    end
  end

  task automatic write_cfg(input logic [7:0] lcr, input logic [4:0] v);
    @(posedge clk); #1; cfg_wr = 1; lcr_value = lcr; cfg_wdata = v;
    @(posedge clk); #1; cfg_wr = 0; lcr_value = 0;
  endtask

  task automatic write_chr(input logic [1:0] s, input logic [7:0] v);
    @(posedge clk); #1; chr_wr = 1; chr_sel = s; chr_wdata = v;
    @(posedge clk); #1; chr_wr = 0;
  endtask

  // drives one byte, then one idle cycle; pushes expectation if it should pass
  task automatic send_rx(input logic [7:0] b, input bit pass);
    if (pass) rx_q.push_back(b);
    @(posedge clk); #1; rx_in_valid = 1; rx_in_data = b;
    @(posedge clk); #1; rx_in_valid = 0;
  endtask

  task automatic fc_request(input logic kind, output int cyc);
    @(posedge clk); #1; fc_req = 1; fc_kind = kind; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!fc_ack && cyc < 100);
    @(posedge clk); #1; fc_req = 0;
  endtask

  task automatic send_data(input logic [7:0] d);
    int n;
    n = 0;
    @(posedge clk); #1; tx_data_valid = 1; tx_data = d;
    do begin @(negedge clk); n++; end while (!tx_data_ready && n < 500);
    @(posedge clk); #1; tx_data_valid = 0;
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rx_q.size() == 0, {rx_tag, " rx queue drained"}, rx_q.size(), 0);
    check(tx_q.size() == 0, {tx_tag, " tx queue drained"}, tx_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int cyc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_halt == 0, "R1 halt after reset", tx_halt, 0);
    check(rx_out_valid == 0, "R1 rx_out_valid after reset", rx_out_valid, 0);
    check(tx_out_valid == 0, "R1 tx_out_valid after reset", tx_out_valid, 0);
    #1; rst_n = 1;

    // R1: reset config off, chars 0: a zero byte passes through
    rx_tag = "R1"; send_rx(8'h00, 1); drain();

    write_chr(2'd0, XON1); write_chr(2'd1, XON2);
    write_chr(2'd2, XOFF1); write_chr(2'd3, XOFF2);

    // R2: locked write ignored
    write_cfg(8'h03, 5'h1A);
    rx_tag = "R2"; send_rx(XOFF1, 1); drain();
    check(tx_halt == 0, "R2 locked write ignored", tx_halt, 0);

    // R3: enable clear
    write_cfg(KEY, 5'h0A);
    rx_tag = "R3"; send_rx(XOFF1, 1); drain();
    check(tx_halt == 0, "R3 disabled no halt", tx_halt, 0);
    tx_tag = "R3"; fc_request(1, cyc); drain();
    check(cyc == 1, "R3 immediate ack", cyc, 1);

    // R4 single, set 1; R7 latency
    write_cfg(KEY, 5'h1A);
    rx_tag = "R7"; rx_q.push_back(8'h41);
    @(posedge clk); #1; rx_in_valid = 1; rx_in_data = 8'h41;
    @(posedge clk); #1; rx_in_valid = 0;
    @(negedge clk);
    check(rx_out_valid && rx_out_data == 8'h41, "R7 one-cycle latency", rx_out_data, 8'h41);
    rx_tag = "R4";
    send_rx(XOFF1, 0); @(negedge clk);
    check(tx_halt == 1, "R4 xoff1 sets halt", tx_halt, 1);
    send_rx(XOFF2, 1); send_rx(XON1, 0); @(negedge clk);
    check(tx_halt == 0, "R4 xon1 clears halt", tx_halt, 0);
    drain();

    // R4 single, set 2
    write_cfg(KEY, 5'h15);
    send_rx(XOFF2, 0); @(negedge clk);
    check(tx_halt == 1, "R4 xoff2 sets halt", tx_halt, 1);
    send_rx(XOFF1, 1); send_rx(XON2, 0); @(negedge clk);
    check(tx_halt == 0, "R4 xon2 clears halt", tx_halt, 0);
    drain();

    // R5 dual
    write_cfg(KEY, 5'h1F);
    rx_tag = "R5";
    send_rx(XOFF1, 0); @(negedge clk);
    check(tx_halt == 0, "R5 half pair no halt", tx_halt, 0);
    send_rx(XOFF2, 0); @(negedge clk);
    check(tx_halt == 1, "R5 pair sets halt", tx_halt, 1);
    send_rx(XON1, 0); send_rx(XON2, 0); @(negedge clk);
    check(tx_halt == 0, "R5 pair clears halt", tx_halt, 0);
    drain();

    // R6 mismatch handling
    rx_tag = "R6";
    send_rx(XOFF1, 0); rx_q.push_back(XOFF1); send_rx(8'h41, 1);
    send_rx(XON1, 0); rx_q.push_back(XON1); send_rx(XOFF1, 0); send_rx(XOFF2, 0);
    @(negedge clk);
    check(tx_halt == 1, "R6 recheck as first char", tx_halt, 1);
    send_rx(XON1, 0); send_rx(XON2, 0);
    send_rx(XOFF1, 0); rx_q.push_back(XOFF1); send_rx(XON2, 1);
    @(negedge clk);
    check(tx_halt == 0, "R6 wrong second keeps state", tx_halt, 0);
    drain();

    // R8 transmit modes and R10 ack timing
    tx_tag = "R8";
    tx_q.push_back(XOFF1); tx_q.push_back(XOFF2); fc_request(1, cyc);
    check(cyc == 3, "R10 ack on second char", cyc, 3);
    write_cfg(KEY, 5'h1A);
    tx_q.push_back(XON1); fc_request(0, cyc);
    check(cyc == 2, "R10 ack on single char", cyc, 2);
    write_cfg(KEY, 5'h15);
    tx_q.push_back(XOFF2); fc_request(1, cyc);
    write_cfg(KEY, 5'h12);
    tx_tag = "R8 mode 00"; fc_request(0, cyc);
    check(cyc == 1, "R8 mode 00 sends nothing", cyc, 1);
    drain();

    // R9 same-cycle request and data: characters first
    write_cfg(KEY, 5'h1A);
    tx_tag = "R9";
    tx_q.push_back(XOFF1); tx_q.push_back(8'h66);
    fork
      send_data(8'h66);
      fc_request(1, cyc);
    join
    drain();

    // R9 halted: characters go, data waits
    rx_tag = "R9"; send_rx(XOFF1, 0);
    tx_q.push_back(XON1); tx_q.push_back(8'h55);
    fork
      send_data(8'h55);
      begin
        fc_request(0, cyc);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(tx_q.size() == 1, "R9 data held while halted", tx_q.size(), 1);
        send_rx(XON1, 0);
      end
    join
    drain();

    // R11 mode change mid-sequence
    write_cfg(KEY, 5'h1F);
    tx_tag = "R11";
    tx_out_ready = 0;
    tx_q.push_back(XON1); tx_q.push_back(XON2);
    fork
      fc_request(0, cyc);
      begin
        repeat (3) @(posedge clk);
        write_cfg(KEY, 5'h1A);
        @(posedge clk); #1; tx_out_ready = 1;
      end
    join
    drain();

    finish_run();
  end
endmodule